// File: doc/BRIEF.md
# Masked Vector XOR Unit

This block is the execution stage for a vector bitwise exclusive-OR. It supports register widths up to 512 bits. Each beat carries four vectors: two sources, the previous destination value, and a 16-bit per-element write mask. The beat also carries control fields that select:

- the encoding class,
- the vector length,
- the element width (32 or 64 bits),
- masking, and merge or zero treatment of disabled elements,
- broadcast of the second source when it comes from memory.

The unit produces the complete new destination value for all 512 bits. Within the active length it computes the lanes. Above the active length it either clears the bits or keeps the old ones, depending on the encoding class.

The input and output are a single valid/ready stream with one register stage. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next edge. The result is held unchanged while `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure reaches the producer in the same cycle. No flags or exceptions are produced. Unsupported combinations return an all-zero vector, marked by `err` on that one output beat.

Top module: `vxor_unit`

## Requirements
- R1: Within the active length, every result bit is 1 when the two operand bits differ and 0 when they are equal. For the plain class (`enc`=1) the operands are `src1` and `src2`.
- R2: `vlen` encodes the active length: 0 selects 64 bits, 1 selects 128, 2 selects 256 and 3 selects 512. In the plain and masked classes (`enc`=1, `enc`=2), every result bit at or above the active length is 0.
- R3: In the masked class with `mask_en`=1, element j is computed only when `kmask[j]` is 1. Elements are 32 bits wide when `ew64`=0 and 64 bits wide when `ew64`=1. Mask bits at or above the element count are ignored, and with 64-bit elements only `kmask[7:0]` count. With `mask_en`=0, or in any other class, all elements are computed.
- R4: A disabled element takes its value from `dst_old` when `zero_mode`=0 and is 0 when `zero_mode`=1.
- R5: In the masked class with `bcast`=1 and `src2_mem`=1, every element uses the lowest element of `src2` as its second operand: bits 31:0 for 32-bit elements, bits 63:0 for 64-bit elements. `bcast` has no effect when `src2_mem`=0 or in any other class.
- R6: In the legacy class (`enc`=0), the result within the active length (64 or 128 bits) is `dst_old` XOR `src2`. All bits above the active length keep their `dst_old` values, and `src1` is not used.
- R7: The following combinations are invalid: legacy with length 256 or 512, plain with length 64 or 512, masked with length 64, and `enc`=3. An invalid combination produces an all-zero result with `err`=1 on that output beat only. `err` is 0 on every valid beat and whenever `out_valid` is 0.
- R8: A beat taken at one edge sets `out_valid` at that edge. `in_ready` equals `!out_valid || out_ready`. While `out_ready` is 0, `out_valid`, `result` and `err` hold. `out_valid` falls after a drain cycle that has no new input.
- R9: Reset (`rst_n`=0) clears `out_valid` and `err` and drives `in_ready` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination value |
| kmask | input | 16 | Per-element write mask |
| vlen | input | 2 | Active length code (R2) |
| ew64 | input | 1 | 1: 64-bit elements, 0: 32-bit |
| mask_en | input | 1 | Apply the write mask |
| zero_mode | input | 1 | Disabled elements: 1 zero, 0 merge |
| bcast | input | 1 | Broadcast request |
| src2_mem | input | 1 | Second source comes from memory |
| enc | input | 2 | Class: 0 legacy, 1 plain, 2 masked, 3 reserved |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 512 | New destination value |
| err | output | 1 | Beat came from an invalid combination |

## Verification
The assertions check the stream contract on every cycle:

- a taken beat is followed by a valid output;
- a stalled output holds its value;
- an empty stage is always ready;
- an error beat carries a zero vector.

The lane arithmetic is shown only by the bench's scenarios:

- mask gating and merge versus zero;
- broadcast and the cases where it is ignored;
- upper-bit clearing or keeping;
- the invalid combinations.

Each scenario is compared against an element-by-element model.

// File: rtl/vxor_pkg.sv
package vxor_pkg;
  localparam int unsigned VX_MAX_W   = 512;
  localparam int unsigned VX_CHUNK_W = 32;
  localparam int unsigned VX_NCHUNK  = VX_MAX_W / VX_CHUNK_W;
  localparam int unsigned VX_MASK_W  = 16;
  localparam int unsigned VX_NACT_W  = $clog2(VX_NCHUNK) + 1;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_PLAIN  = 2'd1,
    ENC_MASKED = 2'd2,
    ENC_RSVD   = 2'd3
  } vx_enc_e;

  typedef enum logic [1:0] {
    VL_64  = 2'd0,
    VL_128 = 2'd1,
    VL_256 = 2'd2,
    VL_512 = 2'd3
  } vx_len_e;
endpackage

// File: rtl/vxor_decode.sv
module vxor_decode
  import vxor_pkg::*;
#(
  parameter int unsigned CHUNK_W = VX_CHUNK_W,
  parameter int unsigned NACT_W  = VX_NACT_W
) (
  input  logic [1:0]        enc,
  input  logic [1:0]        vlen,
  input  logic              mask_en,
  input  logic              bcast,
  input  logic              src2_mem,
  output logic              bad,
  output logic              legacy,
  output logic              mask_use,
  output logic              bcast_go,
  output logic [NACT_W-1:0] nact
);
  localparam int unsigned N64  = 64  / CHUNK_W;
  localparam int unsigned N128 = 128 / CHUNK_W;
  localparam int unsigned N256 = 256 / CHUNK_W;
  localparam int unsigned N512 = 512 / CHUNK_W;

  vx_enc_e ec;
  vx_len_e lc;

  assign ec = vx_enc_e'(enc);
  assign lc = vx_len_e'(vlen);

  always_comb begin
    unique case (lc)
      VL_64:   nact = NACT_W'(N64);
      VL_128:  nact = NACT_W'(N128);
      VL_256:  nact = NACT_W'(N256);
      default: nact = NACT_W'(N512);
    endcase
  end

  always_comb begin
    legacy   = 1'b0;
    mask_use = 1'b0;
    bcast_go = 1'b0;
    unique case (ec)
      ENC_LEGACY: begin
        legacy = 1'b1;
        bad    = !(lc == VL_64 || lc == VL_128);
      end
      ENC_PLAIN: begin
        bad = !(lc == VL_128 || lc == VL_256);
      end
      ENC_MASKED: begin
        bad      = (lc == VL_64);
        mask_use = mask_en;
        bcast_go = bcast && src2_mem;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/vxor_lane_en.sv
module vxor_lane_en
  import vxor_pkg::*;
#(
  parameter int unsigned NCHUNK = VX_NCHUNK,
  parameter int unsigned MASK_W = VX_MASK_W,
  parameter int unsigned NACT_W = VX_NACT_W
) (
  input  logic [MASK_W-1:0] kmask,
  input  logic              ew64,
  input  logic              mask_use,
  input  logic [NACT_W-1:0] nact,
  output logic [NCHUNK-1:0] in_rng,
  output logic [NCHUNK-1:0] on
);
  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    localparam int unsigned L32 = c;
    localparam int unsigned L64 = c / 2;
    logic bit32, bit64;

    if (L32 < MASK_W) begin : g_m32
      assign bit32 = kmask[L32];
    end else begin : g_n32
      assign bit32 = 1'b0;
    end

    if (L64 < MASK_W) begin : g_m64
      assign bit64 = kmask[L64];
    end else begin : g_n64
      assign bit64 = 1'b0;
    end

    assign in_rng[c] = (NACT_W'(c) < nact);
    assign on[c]     = !mask_use || (ew64 ? bit64 : bit32);
  end
endmodule

// File: rtl/vxor_chunk.sv
module vxor_chunk
  import vxor_pkg::*;
#(
  parameter int unsigned W = VX_CHUNK_W
) (
  input  logic [W-1:0] s1,
  input  logic [W-1:0] s2,
  input  logic [W-1:0] old,
  input  logic [W-1:0] bcw,
  input  logic         legacy,
  input  logic         bcast_go,
  input  logic         in_rng,
  input  logic         on,
  input  logic         zero_mode,
  input  logic         bad,
  output logic [W-1:0] y
);
  logic [W-1:0] opa, opb;

  assign opa = legacy   ? old : s1;
  assign opb = bcast_go ? bcw : s2;

  always_comb begin
    if (bad)         y = '0;
    else if (in_rng) y = on ? (opa ^ opb) : (zero_mode ? '0 : old);
    else             y = legacy ? old : '0;
  end
endmodule

// File: rtl/vxor_unit.sv
module vxor_unit
  import vxor_pkg::*;
#(
  parameter int unsigned MAX_W   = VX_MAX_W,
  parameter int unsigned CHUNK_W = VX_CHUNK_W,
  parameter int unsigned MASK_W  = VX_MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MAX_W-1:0]  src1,
  input  logic [MAX_W-1:0]  src2,
  input  logic [MAX_W-1:0]  dst_old,
  input  logic [MASK_W-1:0] kmask,
  input  logic [1:0]        vlen,
  input  logic              ew64,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic              bcast,
  input  logic              src2_mem,
  input  logic [1:0]        enc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MAX_W-1:0]  result,
  output logic              err
);
  localparam int unsigned NCHUNK = MAX_W / CHUNK_W;
  localparam int unsigned NACT_W = $clog2(NCHUNK) + 1;

  logic              bad, legacy, mask_use, bcast_go;
  logic [NACT_W-1:0] nact;
  logic [NCHUNK-1:0] in_rng, on;
  logic [MAX_W-1:0]  nxt;
  logic              accept;

  vxor_decode #(.CHUNK_W(CHUNK_W), .NACT_W(NACT_W)) i_dec (
    .enc(enc), .vlen(vlen), .mask_en(mask_en), .bcast(bcast),
    .src2_mem(src2_mem), .bad(bad), .legacy(legacy),
    .mask_use(mask_use), .bcast_go(bcast_go), .nact(nact)
  );

  vxor_lane_en #(.NCHUNK(NCHUNK), .MASK_W(MASK_W), .NACT_W(NACT_W)) i_len (
    .kmask(kmask), .ew64(ew64), .mask_use(mask_use), .nact(nact),
    .in_rng(in_rng), .on(on)
  );

  for (genvar c = 0; c < NCHUNK; c++) begin : g_lane
    logic [CHUNK_W-1:0] bcw;
    // broadcast word: lowest element, split into halves for 64-bit elements
    assign bcw = ew64 ? src2[(c % 2)*CHUNK_W +: CHUNK_W] : src2[CHUNK_W-1:0];

    vxor_chunk #(.W(CHUNK_W)) i_chunk (
      .s1(src1[c*CHUNK_W +: CHUNK_W]),
      .s2(src2[c*CHUNK_W +: CHUNK_W]),
      .old(dst_old[c*CHUNK_W +: CHUNK_W]),
      .bcw(bcw),
      .legacy(legacy),
      .bcast_go(bcast_go),
      .in_rng(in_rng[c]),
      .on(on[c]),
      .zero_mode(zero_mode),
      .bad(bad),
      .y(nxt[c*CHUNK_W +: CHUNK_W])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      result    <= '0;
    end else begin
      if (in_ready) begin
        out_valid <= in_valid;
        err       <= accept && bad;
      end
      if (accept) result <= nxt;
    end
  end
endmodule

// File: rtl/vxor_unit_chk.sv
module vxor_unit_chk #(
  parameter int unsigned MAX_W = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MAX_W-1:0] result,
  input logic             err
);
  // R8
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(err)));

  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (out_valid && result == '0));
endmodule

bind vxor_unit vxor_unit_chk #(.MAX_W(MAX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .result(result), .err(err)
);

// File: tb/test_vxor_unit.sv
module test_vxor_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 512;

  typedef struct packed {
    logic [1:0]  enc;
    logic [1:0]  vlen;
    logic        ew64;
    logic        men;
    logic        zm;
    logic        bc;
    logic        mem;
    logic [15:0] k;
    logic [7:0]  seed;
  } vec_t;

  // enc: 0 legacy, 1 plain, 2 masked, 3 reserved; vlen: 0..3 = 64..512
  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd1},  // R1 R2
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd2},  // R1 R2
    '{2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hA5C3, 8'd3},  // R3 R4 merge
    '{2'd2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hA5C3, 8'd4},  // R4 zero
    '{2'd2, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFF05, 8'd5},  // R3 high bits
    '{2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd6},  // R3 no mask
    '{2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 8'd7},  // R5 bcast32
    '{2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0009, 8'd8},  // R5 bcast64
    '{2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'd9},  // R5 no mem
    '{2'd0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 8'd10}, // R6 128
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd11}, // R6 64
    '{2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd12}, // R7
    '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd13}, // R7
    '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd14}, // R7
    '{2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd15}, // R7
    '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 8'd16}  // R5 plain
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] src1 = '0, src2 = '0, dst_old = '0;
  logic [15:0] kmask = '0;
  logic [1:0] vlen = '0, enc = '0;
  logic ew64 = 0, mask_en = 0, zero_mode = 0, bcast = 0, src2_mem = 0;
  logic out_valid, out_ready = 1'b1, err;
  logic [W-1:0] result;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vxor_unit i_vxor_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src1(src1), .src2(src2), .dst_old(dst_old), .kmask(kmask),
    .vlen(vlen), .ew64(ew64), .mask_en(mask_en), .zero_mode(zero_mode),
    .bcast(bcast), .src2_mem(src2_mem), .enc(enc),
    .out_valid(out_valid), .out_ready(out_ready), .result(result), .err(err)
  );

  function automatic logic [W-1:0] pat(input logic [7:0] seed, input int which);
    logic [W-1:0] v;
    for (int c = 0; c < 16; c++)
      v[c*32 +: 32] = 32'h9E37_79B9 * (32'(seed) * 32'd16 + 32'(c) + 32'(which) * 32'd997 + 32'd1);
    return v;
  endfunction

  task automatic model(input vec_t t, input logic [W-1:0] a, b, o,
                       output logic [W-1:0] exp, output logic ex_err);
    int vb;
    logic okc;
    vb = 64 << t.vlen;
    case (t.enc)
      2'd0: okc = (t.vlen <= 2'd1);
      2'd1: okc = (t.vlen == 2'd1 || t.vlen == 2'd2);
      2'd2: okc = (t.vlen != 2'd0);
      default: okc = 1'b0;
    endcase
    ex_err = !okc;
    exp = '0;
    if (!okc) return;
    if (t.enc == 2'd0) begin
      exp = o;
      for (int i = 0; i < vb; i++) exp[i] = o[i] ^ b[i];
    end else if (t.enc == 2'd1) begin
      for (int i = 0; i < vb; i++) exp[i] = a[i] ^ b[i];
    end else if (t.ew64) begin
      for (int j = 0; j < vb/64; j++) begin
        logic [63:0] bb;
        bb = (t.bc && t.mem) ? b[63:0] : b[j*64 +: 64];
        if (!t.men || t.k[j]) exp[j*64 +: 64] = a[j*64 +: 64] ^ bb;
        else if (!t.zm)       exp[j*64 +: 64] = o[j*64 +: 64];
      end
    end else begin
      for (int j = 0; j < vb/32; j++) begin
        logic [31:0] bb;
        bb = (t.bc && t.mem) ? b[31:0] : b[j*32 +: 32];
        if (!t.men || t.k[j]) exp[j*32 +: 32] = a[j*32 +: 32] ^ bb;
        else if (!t.zm)       exp[j*32 +: 32] = o[j*32 +: 32];
      end
    end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    enc = t.enc; vlen = t.vlen; ew64 = t.ew64; mask_en = t.men;
    zero_mode = t.zm; bcast = t.bc; src2_mem = t.mem; kmask = t.k;
    src1 = pat(t.seed, 1); src2 = pat(t.seed, 2); dst_old = pat(t.seed, 3);
    in_valid = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] e, held;
    logic ee;
    vec_t t;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", W'(out_valid), '0);
    chk("R9 in_ready", W'(in_ready), W'(1));
    chk("R9 err", W'(err), '0);
    rst_n = 1'b1;

    foreach (TBL[i]) begin
      @(negedge clk);
      drive(TBL[i]);
      model(TBL[i], src1, src2, dst_old, e, ee);
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R8 valid v%0d", i), W'(out_valid), W'(1));
      chk($sformatf("R1-R7 result v%0d", i), result, e);
      chk($sformatf("R7 err v%0d", i), W'(err), W'(ee));
    end

    // R8 drain without new input drops out_valid
    @(negedge clk);
    chk("R8 idle", W'(out_valid), '0);

    // R3: mask bits above 64-bit lane count ignored
    t = TBL[4];
    t.k = 16'h0005;
    @(negedge clk); drive(t); model(t, src1, src2, dst_old, e, ee);
    @(negedge clk); in_valid = 1'b0;
    held = result;
    t.k = 16'hFF05;
    @(negedge clk); drive(t);
    @(negedge clk); in_valid = 1'b0;
    chk("R3 high mask ignored", result, held);

    // R8 stall: result held, in_ready low
    t = TBL[2];
    @(negedge clk); drive(t); model(t, src1, src2, dst_old, e, ee);
    out_ready = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 stall valid", W'(out_valid), W'(1));
    chk("R8 stall ready", W'(in_ready), '0);
    chk("R8 stall result", result, e);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 after drain", W'(out_valid), '0);

    // R7 err for one beat only, back-to-back
    @(negedge clk); drive(TBL[11]);
    @(negedge clk);
    chk("R7 err beat", W'(err), W'(1));
    chk("R7 zero beat", result, '0);
    drive(TBL[0]); model(TBL[0], src1, src2, dst_old, e, ee);
    @(negedge clk); in_valid = 1'b0;
    chk("R7 err cleared", W'(err), '0);
    chk("R1 after err", result, e);

    // R9 reset mid-stream
    @(negedge clk); drive(TBL[11]);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    #1;
    chk("R9 async valid", W'(out_valid), '0);
    chk("R9 async err", W'(err), '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule